// File: doc/BRIEF.md
# Fractional-N Feedback Divider with First-Order Noise Shaping

This block sits in the feedback path of a fractional-N phase-locked loop and runs on the oscillator clock. It divides that clock by a ratio that may have a fractional part. The ratio is given as an integer word and a fractional word. A multimodulus down counter produces one output period per terminal count. At each terminal count a first-order noise-shaping accumulator picks the next modulus, either the integer word or one more than it. Over many periods the average ratio therefore equals the integer word plus the fractional word divided by 2^16.

The phase detector compares the divided pulse with the reference. The modulus now in use is also brought out, so that neighbouring logic can follow the dithering sequence. The fractional width sets the frequency resolution and is a parameter. A wider word gives a finer step at the cost of a few adder bits.

Top module: `frac_div_ctrl`

## Requirements
- R1: A clock edge with `rst_n` low clears the accumulator to zero and starts a new period whose modulus is the clamped integer word. `cur_mod` shows that modulus in the next cycle, and the first `div_pulse` comes in the modulus-th cycle after that edge.
- R2: `div_pulse` is high for exactly one cycle per output period, in its last cycle. A period lasts exactly `cur_mod` cycles.
- R3: The modulus of each period is M or M+1, where M is the clamped integer word sampled at the terminal count that starts the period. It is M+1 exactly when adding the 16-bit fractional word to the 16-bit accumulator carries out of bit 15. The accumulator keeps the 16-bit sum.
- R4: `cur_mod` changes only at the edge that ends a period. A change of either input word during a period has no effect on that period's length.
- R5: With the words held constant, the periods after the first one after reset follow the first-order carry sequence. Any 2^16 consecutive such periods span exactly M·2^16 + F oscillator cycles.
- R6: A fractional word of zero gives every period exactly M cycles.
- R7: An integer word below 4 is treated as 4.
- R8: An integer word of 255 with a carry gives a 256-cycle period, and `cur_mod` shows 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| int_word | input | 8 | Integer part of the division ratio |
| frac_word | input | 16 | Fractional part of the division ratio, in units of 2^-16 |
| div_pulse | output | 1 | High in the last cycle of each output period |
| cur_mod | output | 9 | Modulus of the period in progress |

## Verification
A wrong accumulator value does not show in the current period. It shows at the next terminal count, where a carry is missed or an extra one appears. The fault is then one period off in length and in `cur_mod`, and a window sum over many periods is off by the number of wrong carries. A counter fault is seen within one period: `div_pulse` comes a cycle early or late, or more than once. The bench runs its own model cycle by cycle, so either kind of fault is caught at the first cycle where it reaches a port.

// File: rtl/frac_div_pkg.sv
// Package: default sizes shared by the fractional divider modules.
// Assumes: the integer word is at least 3 bits wide so the minimum modulus fits.
package frac_div_pkg;
    localparam int FD_FRAC_W_DEF  = 16;  // fractional word width
    localparam int FD_INT_W_DEF   = 8;   // integer word width
    localparam int FD_MIN_MOD_DEF = 4;   // smallest modulus the counter supports
endpackage

// File: rtl/fd_modsel.sv
// Modulus selector: clamps the integer word to the minimum modulus and adds
// the carry from the noise-shaping accumulator.
// Assumes: MIN_MOD is representable in INT_W bits.
module fd_modsel #(
    parameter int INT_W   = frac_div_pkg::FD_INT_W_DEF,
    parameter int MIN_MOD = frac_div_pkg::FD_MIN_MOD_DEF
) (
    input  logic [INT_W-1:0] int_word,
    input  logic             carry,
    output logic [INT_W:0]   base_mod,
    output logic [INT_W:0]   next_mod
);
    localparam logic [INT_W-1:0] MIN_V = INT_W'(MIN_MOD);

    logic [INT_W-1:0] clamped;

    // Clamp the integer word from below.
    always_comb begin
        clamped = (int_word < MIN_V) ? MIN_V : int_word;
    end

    // Widen the clamped value and add the dither carry.
    always_comb begin
        base_mod = {1'b0, clamped};
        next_mod = base_mod + {{INT_W{1'b0}}, carry};
    end
endmodule

// File: rtl/fd_accum.sv
// First-order noise-shaping accumulator: adds the fractional word once per
// output period and gives the carry out of that sum for the next modulus.
// Assumes: step is high for exactly one cycle per period.
module fd_accum #(
    parameter int FRAC_W = frac_div_pkg::FD_FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry,
    output logic [FRAC_W-1:0] acc_q
);
    logic [FRAC_W:0] sum;

    // Sum of the stored phase and the fractional word, with carry.
    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, frac};
        carry = sum[FRAC_W];
    end

    // Store the wrapped sum at each period boundary; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (step)
            acc_q <= sum[FRAC_W-1:0];
    end

    // R5
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(acc_q));

    // R1
    acc_clear_chk: assert property (@(posedge clk)
        !rst_n |=> acc_q == '0);
endmodule

// File: rtl/fd_counter.sv
// Multimodulus down counter: runs a period of cur_mod cycles and flags the
// last one. A new modulus is taken only at terminal count.
// Assumes: every modulus given to it is at least 2.
module fd_counter #(
    parameter int CNT_W = frac_div_pkg::FD_INT_W_DEF + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reset_mod,
    input  logic [CNT_W-1:0] load_mod,
    output logic             tc,
    output logic [CNT_W-1:0] cur_mod
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // Terminal count marks the last cycle of the period.
    always_comb begin
        tc = (cnt == '0);
    end

    // Count down, or reload with a fresh modulus at reset or terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= reset_mod - ONE;
            cur_mod <= reset_mod;
        end else if (tc) begin
            cnt     <= load_mod - ONE;
            cur_mod <= load_mod;
        end else begin
            cnt     <= cnt - ONE;
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < cur_mod);

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> cnt == cur_mod - ONE);

    // R4
    mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tc |=> $stable(cur_mod));
endmodule

// File: rtl/frac_div_ctrl.sv
// Fractional-N feedback divider: a multimodulus counter whose modulus is
// dithered between N and N+1 by a first-order accumulator, once per period.
// Assumes: runs on the oscillator clock; words may change at any time and
// are sampled only at terminal count (or during reset).
module frac_div_ctrl #(
    parameter int FRAC_W  = frac_div_pkg::FD_FRAC_W_DEF,
    parameter int INT_W   = frac_div_pkg::FD_INT_W_DEF,
    parameter int MIN_MOD = frac_div_pkg::FD_MIN_MOD_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  int_word,
    input  logic [FRAC_W-1:0] frac_word,
    output logic              div_pulse,
    output logic [INT_W:0]    cur_mod
);
    localparam int CNT_W = INT_W + 1;
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_MOD);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(1 << INT_W);

    logic              tc;
    logic              carry;
    logic [FRAC_W-1:0] acc_q;
    logic [CNT_W-1:0]  base_mod;
    logic [CNT_W-1:0]  next_mod;

    fd_accum #(.FRAC_W(FRAC_W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (tc),
        .frac  (frac_word),
        .carry (carry),
        .acc_q (acc_q)
    );

    fd_modsel #(.INT_W(INT_W), .MIN_MOD(MIN_MOD)) u_modsel (
        .int_word (int_word),
        .carry    (carry),
        .base_mod (base_mod),
        .next_mod (next_mod)
    );

    fd_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_mod (base_mod),
        .load_mod  (next_mod),
        .tc        (tc),
        .cur_mod   (cur_mod)
    );

    // Drive the divided pulse from terminal count.
    always_comb begin
        div_pulse = tc;
    end

    // R7
    mod_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mod >= MIN_C);

    // R8
    mod_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mod <= MAX_C);

    // R3
    mod_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (cur_mod == $past(base_mod)) || (cur_mod == $past(base_mod) + 1'b1));

    // R5
    acc_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && frac_word == '0) |=> $stable(acc_q));
endmodule

// File: tb/sim_frac_div_ctrl.sv
module sim_frac_div_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  int_word = 8'd6;
    logic [15:0] frac_word = 16'd0;
    logic        div_pulse;
    logic [8:0]  cur_mod;

    int total = 0;
    int bad   = 0;

    // reference model state
    int  m_left = 0;
    int  m_mod  = 0;
    int  m_acc  = 0;
    bit  m_ok   = 1'b0;

    frac_div_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_word  (int_word),
        .frac_word (frac_word),
        .div_pulse (div_pulse),
        .cur_mod   (cur_mod)
    );

    always #5 clk = ~clk;

    function automatic int clampn(input int n);
        return (n < 4) ? 4 : n;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural model: remaining cycles, modulus, phase accumulator.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mod  = clampn(int_word);
            m_left = m_mod;
            m_acc  = 0;
            m_ok   = 1'b1;
        end else if (m_ok) begin
            if (m_left == 1) begin
                int s;
                s      = m_acc + frac_word;
                m_acc  = s % 65536;
                m_mod  = clampn(int_word) + ((s >= 65536) ? 1 : 0);
                m_left = m_mod;
            end else begin
                m_left = m_left - 1;
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (m_ok && rst_n) begin
            chk(div_pulse == (m_left == 1), "R2 pulse", div_pulse, (m_left == 1));
            chk(cur_mod == m_mod, "R3 modulus", cur_mod, m_mod);
        end
    end

    task automatic do_reset(input int n, input int f);
        @(negedge clk);
        rst_n = 1'b0;
        int_word = 8'(n);
        frac_word = 16'(f);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic sync_pulse();
        @(negedge clk);
        while (!div_pulse) @(negedge clk);
    endtask

    task automatic measure(input int periods, output longint tot);
        int k = 0;
        tot = 0;
        while (k < periods) begin
            @(negedge clk);
            tot++;
            if (div_pulse) k++;
        end
    endtask

    initial begin
        #1500000;
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint t;
        int c;
        // R1: reset state and first period
        @(negedge clk);
        @(negedge clk);
        chk(cur_mod == 9'd6, "R1 reset modulus", cur_mod, 6);
        chk(div_pulse == 1'b0, "R1 reset pulse", div_pulse, 0);
        rst_n = 1'b1;
        c = 1;
        while (!div_pulse) begin @(negedge clk); c++; end
        chk(c == 6, "R1 first period", c, 6);

        // R6: integer mode
        measure(5, t);
        chk(t == 30, "R6 five periods", t, 30);

        // R1 + R5: accumulator cleared, carry on 4th step
        do_reset(4, 16'h4000);
        sync_pulse();
        measure(3, t);
        chk(t == 12, "R1 acc cleared", t, 12);
        measure(1, t);
        chk(t == 5, "R5 carry period", t, 5);

        // R5: window sums
        do_reset(4, 16'h0010);
        sync_pulse();
        measure(4096, t);
        chk(t == 16385, "R5 window 0x0010", t, 16385);
        do_reset(4, 16'hFFFF);
        sync_pulse();
        measure(16, t);
        chk(t == 79, "R5 window 0xFFFF", t, 79);
        do_reset(7, 16'h2000);
        sync_pulse();
        measure(8, t);
        chk(t == 57, "R5 window 0x2000", t, 57);

        // R4: mid-period word change ignored until next period
        do_reset(10, 0);
        sync_pulse();
        c = 0;
        repeat (3) begin @(negedge clk); c++; end
        int_word = 8'd20;
        frac_word = 16'hFFFF;
        chk(cur_mod == 9'd10, "R4 mod held", cur_mod, 10);
        while (!div_pulse) begin @(negedge clk); c++; end
        chk(c == 10, "R4 period kept", c, 10);
        frac_word = 16'd0;
        measure(1, t);
        chk(t == 20, "R4 new word", t, 20);

        // R7: clamp below minimum
        do_reset(2, 0);
        chk(cur_mod == 9'd4, "R7 clamp modulus", cur_mod, 4);
        sync_pulse();
        measure(2, t);
        chk(t == 8, "R7 clamp periods", t, 8);
        do_reset(0, 0);
        sync_pulse();
        measure(1, t);
        chk(t == 4, "R7 zero word", t, 4);

        // R8: top of range
        do_reset(255, 16'h8000);
        sync_pulse();
        measure(2, t);
        chk(t == 511, "R8 two periods", t, 511);
        chk(cur_mod == 9'd256, "R8 modulus 256", cur_mod, 256);
        measure(1, t);
        chk(t == 255, "R8 following period", t, 255);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule